// File: doc/BRIEF.md
# DMA Interrupt Mask and Latch

This block collects the DMA-side interrupt events of a bus-mastering controller. Each event pulse from the DMA or script engine sets a sticky flag in a status register. A summary "pending" output is high whenever any flag is set. An enable register selects which flags may drive the active-low interrupt pin. The mask gates only the pin. A masked event still records its flag, still raises the pending summary, and still asks the script engine to halt, because every DMA event is treated as fatal.

The interrupt pin is registered and latched. Once it goes low it stays low until software reads the status register, and that read also clears the flags. Changing the mask afterwards has no effect on a pin that is already low. The halt request stays up until the flags have been cleared and the engine acknowledges a restart on a separate input.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the interrupt pin is high, and both the pending summary and the halt request are low.
- R2: A write with select 0 loads the enable register, and a read with select 0 returns it. The defined bits are 6 (parity error), 5 (bus fault), 4 (abort), 3 (single step), 2 (script interrupt) and 0 (illegal instruction). Bits 7 and 1 are reserved: writes to them are ignored and they read as 0.
- R3: An event pulse on a defined source bit sets the matching status flag on the next clock edge, whatever the mask. Event pulses on bits 7 and 1 have no effect on the status, the pending summary or the halt request.
- R4: The pending summary is high in the cycle after any status flag is set, including a flag whose enable bit is 0.
- R5: The interrupt pin goes low on the clock edge after a status flag with its enable bit set is present, which is two edges after the event. A flag whose enable bit is 0 leaves the pin high.
- R6: Clearing enable bits while the pin is low does not release the pin.
- R7: A read with select 1 returns the status flags in the same cycle. The read clears the flags, the pending summary, and the pin latch on that clock edge.
- R8: An event that arrives in the same cycle as a clearing read is kept in the status register. If that source is enabled, the pin goes low again one edge later.
- R9: Any defined event raises the halt request on the next edge, whether or not it is masked.
- R10: The halt request drops only on the edge after restart_ack_i is high while the status is zero and no new event arrives. An acknowledge given while flags are still set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status when select is 1) |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| src_evt_i | input | 8 | Per-source event pulses, same bit layout as the registers |
| restart_ack_i | input | 1 | Script engine restart acknowledge |
| dma_pend_o | output | 1 | DMA interrupt pending summary |
| halt_req_o | output | 1 | Halt request to the script engine |
| irq_n_o | output | 1 | Latched interrupt pin, active low |

## Verification
The clearing status read and a new event pulse can fall in the same cycle. The two compete for the status register and for the pin latch. The bench provokes this by driving an enabled event together with a status read while the pin is already low. It then expects the read data to show only the old flags, and the pin to go high for exactly one cycle before it falls again. A later read must return the flag that was kept. A restart acknowledge given while flags are still set is also driven, to check that it does not drop the halt request.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int unsigned DW = 8;

  // source bit positions (the register layout depends on these)
  localparam int unsigned SRC_ILLEGAL = 0;
  localparam int unsigned SRC_SCRIPT  = 2;
  localparam int unsigned SRC_STEP    = 3;
  localparam int unsigned SRC_ABORT   = 4;
  localparam int unsigned SRC_BUSFLT  = 5;
  localparam int unsigned SRC_PARITY  = 6;

  function automatic logic [DW-1:0] defined_mask();
    logic [DW-1:0] m;
    m = '0;
    m[SRC_ILLEGAL] = 1'b1;
    m[SRC_SCRIPT]  = 1'b1;
    m[SRC_STEP]    = 1'b1;
    m[SRC_ABORT]   = 1'b1;
    m[SRC_BUSFLT]  = 1'b1;
    m[SRC_PARITY]  = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] DEF_MASK = defined_mask();

  // keep only bits that name a real source
  function automatic logic [DW-1:0] keep_defined(input logic [DW-1:0] v);
    return v & DEF_MASK;
  endfunction

  // next value of one status flag: new event wins over a clearing read
  function automatic logic flag_next(input logic cur, input logic clr, input logic evt);
    return (cur & ~clr) | evt;
  endfunction

  // next value of the pin latch: read clears, any enabled flag sets
  function automatic logic latch_next(input logic cur, input logic clr, input logic set);
    return clr ? 1'b0 : (cur | set);
  endfunction

  // next value of the halt request
  function automatic logic halt_next(input logic cur, input logic evt, input logic ack,
                                     input logic sts_zero);
    return evt | (cur & ~(ack & sts_zero));
  endfunction

  typedef enum logic {SEL_ENABLE = 1'b0, SEL_STATUS = 1'b1} reg_sel_e;

endpackage

// File: rtl/dmairq_enable_reg.sv
module dmairq_enable_reg
  import dmairq_pkg::*;
#(
  parameter int unsigned          W    = DW,
  parameter logic [W-1:0]         LIVE = DEF_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bit_q <= 1'b0;
        else if (wr_i) bit_q <= wdata_i[i];
      end
      assign en_o[i] = bit_q;
    end else begin : g_rsvd
      assign en_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/dmairq_status_reg.sv
module dmairq_status_reg
  import dmairq_pkg::*;
#(
  parameter int unsigned  W    = DW,
  parameter logic [W-1:0] LIVE = DEF_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] sts_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= flag_next(bit_q, clr_i, evt_i[i]);
      end
      assign sts_o[i] = bit_q;
    end else begin : g_rsvd
      assign sts_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/dmairq_pin_latch.sv
module dmairq_pin_latch
  import dmairq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  output logic irq_n_o
);

  logic lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= latch_next(lat_q, clr_i, set_i);
  end

  assign irq_n_o = ~lat_q;

endmodule

// File: rtl/dmairq_halt_ctrl.sv
module dmairq_halt_ctrl
  import dmairq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic ack_i,
  input  logic sts_zero_i,
  output logic halt_o
);

  logic halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_next(halt_q, evt_i, ack_i, sts_zero_i);
  end

  assign halt_o = halt_q;

endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic          reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] src_evt_i,
  input  logic          restart_ack_i,
  output logic          dma_pend_o,
  output logic          halt_req_o,
  output logic          irq_n_o
);

  // named internal events, also seen by the checker
  logic [DW-1:0] ev_vld;
  logic          ev_any;
  logic          en_wr;
  logic          rd_clr;
  logic [DW-1:0] en_q;
  logic [DW-1:0] sts_q;
  logic          pin_set;
  logic          sts_zero;

  assign ev_vld   = keep_defined(src_evt_i);
  assign ev_any   = |ev_vld;
  assign en_wr    = reg_wr_i & (reg_sel_i == SEL_ENABLE);
  assign rd_clr   = reg_rd_i & (reg_sel_i == SEL_STATUS);
  assign pin_set  = |(sts_q & en_q);
  assign sts_zero = (sts_q == '0);

  dmairq_enable_reg #(.W(DW), .LIVE(DEF_MASK)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (en_wr),
    .wdata_i (reg_wdata_i),
    .en_o    (en_q)
  );

  dmairq_status_reg #(.W(DW), .LIVE(DEF_MASK)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (rd_clr),
    .evt_i (ev_vld),
    .sts_o (sts_q)
  );

  dmairq_pin_latch u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (rd_clr),
    .set_i   (pin_set),
    .irq_n_o (irq_n_o)
  );

  dmairq_halt_ctrl u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (ev_any),
    .ack_i      (restart_ack_i),
    .sts_zero_i (sts_zero),
    .halt_o     (halt_req_o)
  );

  assign reg_rdata_o = (reg_sel_i == SEL_STATUS) ? sts_q : en_q;
  assign dma_pend_o  = ~sts_zero;

endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk
  import dmairq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] ev_vld,
  input logic          rd_clr,
  input logic [DW-1:0] sts_q,
  input logic [DW-1:0] en_q,
  input logic          irq_n_o,
  input logic          halt_req_o,
  input logic          dma_pend_o,
  input logic          restart_ack_i
);

  // R2
  always @(posedge clk) if (rst_n) rsvd_zero_chk: assert ((en_q & ~DEF_MASK) == '0);

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vld) |=> ((sts_q & $past(ev_vld)) == $past(ev_vld)));

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vld) |=> dma_pend_o);

  // R5
  pin_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & en_q) && !rd_clr) |=> !irq_n_o);

  // R6
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !rd_clr) |=> !irq_n_o);

  // R7
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> irq_n_o);

  // R9
  halt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vld) |=> halt_req_o);

  // R10
  halt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req_o && (sts_q != '0)) |=> halt_req_o);

  // R10
  halt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req_o && restart_ack_i && (sts_q == '0) && !(|ev_vld)) |=> !halt_req_o);

endmodule

bind dmairq_ctrl dmairq_ctrl_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_vld        (ev_vld),
  .rd_clr        (rd_clr),
  .sts_q         (sts_q),
  .en_q          (en_q),
  .irq_n_o       (irq_n_o),
  .halt_req_o    (halt_req_o),
  .dma_pend_o    (dma_pend_o),
  .restart_ack_i (restart_ack_i)
);

// File: tb/dmairq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmairq_ctrl_tb_top;

  localparam int SIG_RDATA = 0;
  localparam int SIG_PIN   = 1;
  localparam int SIG_PEND  = 2;
  localparam int SIG_HALT  = 3;

  typedef struct {
    int         due;
    int         sig;
    logic [7:0] val;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, evt = '0;
  logic [7:0] rdata;
  logic       pend, halt, irq_n;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  dmairq_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_i      (reg_wr),
    .reg_rd_i      (reg_rd),
    .reg_sel_i     (reg_sel),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .src_evt_i     (evt),
    .restart_ack_i (ack),
    .dma_pend_o    (pend),
    .halt_req_o    (halt),
    .irq_n_o       (irq_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] observe(int sig);
    case (sig)
      SIG_RDATA: return rdata;
      SIG_PIN:   return {7'd0, irq_n};
      SIG_PEND:  return {7'd0, pend};
      default:   return {7'd0, halt};
    endcase
  endfunction

  // monitor: compares every expected item in its cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].due == cyc) begin
          total++;
          if (observe(exp_q[i].sig) !== exp_q[i].val) begin
            bad++;
            $display("FAIL %s sig=%0d actual=%0h expected=%0h cyc=%0d", exp_q[i].req,
                     exp_q[i].sig, observe(exp_q[i].sig), exp_q[i].val, cyc);
          end
          exp_q.delete(i);
        end else if (exp_q[i].due < cyc) begin
          total++;
          bad++;
          $display("FAIL %s missed sample actual=none expected=%0h", exp_q[i].req, exp_q[i].val);
          exp_q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(int d, int sig, logic [7:0] v, string req);
    exp_t e;
    e.due = cyc + d;
    e.sig = sig;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // one cycle of stimulus; called just after a rising edge
  task automatic op(logic [7:0] ev, logic wr, logic rd, logic sel, logic [7:0] wd, logic ak);
    evt = ev; reg_wr = wr; reg_rd = rd; reg_sel = sel; wdata = wd; ack = ak;
    @(posedge clk); #1;
    evt = '0; reg_wr = 1'b0; reg_rd = 1'b0; ack = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) op(8'h00, 1'b0, 1'b0, reg_sel, 8'h00, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    expect_at(0, SIG_PIN, 8'h01, "R1");
    expect_at(0, SIG_PEND, 8'h00, "R1");
    expect_at(0, SIG_HALT, 8'h00, "R1");
    expect_at(0, SIG_RDATA, 8'h00, "R1");
    op(8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);

    // R2 reserved enable bits read 0
    op(8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0);
    expect_at(0, SIG_RDATA, 8'h7D, "R2");
    op(8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);

    // masked parity event: flag, pending, halt, but no pin
    op(8'h00, 1'b1, 1'b0, 1'b0, 8'h04, 1'b0);
    expect_at(1, SIG_PEND, 8'h01, "R4");
    expect_at(1, SIG_HALT, 8'h01, "R9");
    expect_at(2, SIG_PIN, 8'h01, "R5");
    expect_at(3, SIG_PIN, 8'h01, "R5");
    op(8'h40, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    idle(2);
    // R10 acknowledge with flags set is ignored
    expect_at(1, SIG_HALT, 8'h01, "R10");
    op(8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
    // R3 / R7 read returns and clears
    expect_at(0, SIG_RDATA, 8'h40, "R3");
    expect_at(1, SIG_PEND, 8'h00, "R7");
    expect_at(1, SIG_HALT, 8'h01, "R10");
    op(8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    expect_at(1, SIG_HALT, 8'h00, "R10");
    op(8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);

    // R3 reserved event bits ignored
    expect_at(1, SIG_PEND, 8'h00, "R3");
    expect_at(1, SIG_HALT, 8'h00, "R3");
    op(8'h82, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    expect_at(0, SIG_RDATA, 8'h00, "R3");
    op(8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);

    // R5 enabled script-interrupt event drives pin
    expect_at(1, SIG_PIN, 8'h01, "R5");
    expect_at(1, SIG_PEND, 8'h01, "R4");
    expect_at(2, SIG_PIN, 8'h00, "R5");
    op(8'h04, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    idle(1);
    // R6 mask after assertion keeps pin low
    expect_at(1, SIG_PIN, 8'h00, "R6");
    expect_at(3, SIG_PIN, 8'h00, "R6");
    op(8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(3);
    // R7 read releases pin
    expect_at(0, SIG_RDATA, 8'h04, "R7");
    expect_at(1, SIG_PIN, 8'h01, "R7");
    expect_at(1, SIG_PEND, 8'h00, "R7");
    op(8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);

    // R8 event together with clearing read
    op(8'h00, 1'b1, 1'b0, 1'b0, 8'h01, 1'b0);
    reg_sel = 1'b1;
    op(8'h01, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    idle(2);
    expect_at(0, SIG_RDATA, 8'h01, "R8");
    expect_at(1, SIG_PIN, 8'h01, "R8");
    expect_at(1, SIG_PEND, 8'h01, "R8");
    expect_at(2, SIG_PIN, 8'h00, "R8");
    op(8'h01, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    idle(2);
    expect_at(0, SIG_RDATA, 8'h01, "R8");
    expect_at(1, SIG_PIN, 8'h01, "R7");
    op(8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    expect_at(1, SIG_HALT, 8'h00, "R10");
    op(8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);

    // several sources at once, mixed mask
    op(8'h00, 1'b1, 1'b0, 1'b0, 8'h20, 1'b0);
    expect_at(2, SIG_PIN, 8'h00, "R5");
    op(8'h28, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    idle(2);
    expect_at(0, SIG_RDATA, 8'h28, "R3");
    op(8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);

    idle(4);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL queue actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

endmodule